// File: doc/BRIEF.md
# Accumulator Transfer and Logic Sequencer

This block moves a value from one of four 16-bit accumulators to another, and on request merges the moving value with the destination's current contents through AND, OR or XOR before the write. The accumulators live in a seven-entry register file together with two index registers and a stack register. That file has exactly one read port, so a two-operand merge reads its operands one after the other and holds the first in a latch. A plain move needs two busy cycles (read, then write). A merged move needs three (read source, read destination, write).

A caller presents a 16-bit opcode with a one-cycle start strobe while the block is idle. Opcodes outside the transfer family are dropped without any effect. While the sequencer is idle, the read port serves an observation select. A load port lets the surrounding core place values in any of the seven registers. The zero and negative flags follow every value the sequencer writes.

Top module: `acc_xfer_unit`

## Requirements
- R1: An opcode is accepted only when bits [15:12] are 0000, bits [7:6] are 10 and bits [3:0] are 1011. Any other opcode presented with `start` leaves every register, both flags and `busy` unchanged.
- R2: Opcode bits [5:4] name the source and bits [9:8] name the destination. Both fields use the encoding 00=A, 01=B, 10=C, 11=D. For example, 16'h018B moves A into B and 16'h009B moves B into A.
- R3: With bits [11:10] = 00, `busy` is high for exactly two cycles after the accepting edge. At the end, the destination holds the source's value and every other register is unchanged.
- R4: A transfer whose source and destination are the same accumulator leaves that accumulator's value unchanged.
- R5: Bits [11:10] pick the merge: 01 = AND, 10 = OR, 11 = XOR. The result written is (source op destination).
- R6: A merged transfer keeps `busy` high for exactly three cycles after the accepting edge and writes only the destination.
- R7: While `busy` is low, `rd_data` shows the register named by `peek_sel`, using the encoding 0=A, 1=B, 2=C, 3=D, 4=X, 5=Y, 6=S. A select of 7 reads zero.
- R8: `done` is a single-cycle pulse in the last busy cycle. A `start` that arrives while `busy` is high is ignored.
- R9: In the cycle after `done`, `flag_z` shows whether the written value was zero and `flag_n` equals its bit 15. At all other times the flags hold their values.
- R10: While `busy` is low, `load_en` writes `load_data` into the register named by `load_sel` (same encoding as R7; 7 writes nothing). While `busy` is high, `load_en` is ignored. Transfers never write X, Y or S.
- R11: A synchronous `rst` clears all seven registers and both flags, and returns the sequencer to idle, including in the middle of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to run `opcode` |
| opcode | input | 16 | Transfer instruction word |
| load_en | input | 1 | Load request from the surrounding core |
| load_sel | input | 3 | Register chosen for the load |
| load_data | input | 16 | Value to load |
| peek_sel | input | 3 | Register shown on `rd_data` while idle |
| rd_data | output | 16 | Output of the single read port |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Final (write) cycle of a transfer |
| flag_z | output | 1 | Last written value was zero |
| flag_n | output | 1 | Bit 15 of the last written value |

## Verification
The embedded properties assume that `start` is meaningful only in idle cycles, and that `rst` is applied at a clock edge and not released mid-cycle. They do not depend on how the load and observation inputs are driven. The stimulus changes inputs one time unit after each rising edge. It raises `start` for one cycle per request, except where it deliberately repeats the strobe and the load inside a busy window to exercise R8 and R10. The reference model then expects both of those to be dropped. The bench steps `peek_sel` through all eight codes on consecutive cycles, so every idle stretch of eight cycles exposes the whole register file.

// File: rtl/acc_xfer_pkg.sv
package acc_xfer_pkg;

   typedef enum logic [1:0] {
      XOP_MOVE = 2'b00,
      XOP_AND  = 2'b01,
      XOP_OR   = 2'b10,
      XOP_XOR  = 2'b11
   } xop_e;

   typedef enum logic [1:0] {
      SQ_IDLE   = 2'd0,
      SQ_RD_SRC = 2'd1,
      SQ_RD_DST = 2'd2,
      SQ_WRITE  = 2'd3
   } seq_e;

   typedef struct packed {
      logic       hit;
      logic [1:0] src;
      logic [1:0] dst;
      xop_e       op;
   } xfer_cmd_t;

   localparam int ACC_SEL_W = 2;

endpackage

// File: rtl/acc_xfer_decode.sv
module acc_xfer_decode
   import acc_xfer_pkg::*;
#(
   parameter int OPC_W    = 16,
   parameter bit LOGIC_EN = 1'b1
) (
   input  logic [OPC_W-1:0] opcode,
   output xfer_cmd_t        cmd
);

   if (OPC_W != 16) begin : g_bad_width
      $error("acc_xfer_decode: OPC_W must be 16");
   end

   logic family;
   logic [1:0] op_bits;

   always_comb begin
      family  = (opcode[15:12] == 4'b0000) &&
                (opcode[7:6]   == 2'b10)   &&
                (opcode[3:0]   == 4'b1011);
      op_bits = opcode[11:10];
   end

   if (LOGIC_EN) begin : g_logic
      always_comb begin
         cmd.hit = family;
         cmd.op  = xop_e'(op_bits);
      end
   end else begin : g_move_only
      always_comb begin
         cmd.hit = family && (op_bits == 2'b00);
         cmd.op  = XOP_MOVE;
      end
   end

   always_comb begin
      cmd.src = opcode[5:4];
      cmd.dst = opcode[9:8];
   end

endmodule

// File: rtl/acc_xfer_regfile.sv
module acc_xfer_regfile #(
   parameter int DATA_W = 16,
   parameter int NREG   = 7,
   parameter int SEL_W  = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [SEL_W-1:0]  rd_sel,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [DATA_W-1:0] wr_data
);

   if (NREG > (1 << SEL_W)) begin : g_bad_sel
      $error("acc_xfer_regfile: SEL_W too narrow for NREG");
   end

   logic [DATA_W-1:0] q [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst)
            q[i] <= '0;
         else if (wr_en && (wr_sel == SEL_W'(i)))
            q[i] <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NREG; i++) begin
         if (rd_sel == SEL_W'(i))
            rd_data = q[i];
      end
   end

   // R11: the first cycle after reset presents a cleared file on the port
   a_r11_cleared_after_reset: assert property (@(posedge clk)
      $fell(rst) |-> (q[0] == '0 && q[NREG-1] == '0));

endmodule

// File: rtl/acc_xfer_seq.sv
module acc_xfer_seq
   import acc_xfer_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 start,
   input  xfer_cmd_t            cmd,
   output seq_e                 state,
   output xfer_cmd_t            cmd_q,
   output logic [ACC_SEL_W-1:0] rd_acc,
   output logic                 busy,
   output logic                 done
);

   seq_e state_q, state_d;
   logic accept;

   always_comb begin
      accept  = start && cmd.hit && (state_q == SQ_IDLE);
      state_d = state_q;
      unique case (state_q)
         SQ_IDLE:   if (accept) state_d = SQ_RD_SRC;
         SQ_RD_SRC: state_d = (cmd_q.op == XOP_MOVE) ? SQ_WRITE : SQ_RD_DST;
         SQ_RD_DST: state_d = SQ_WRITE;
         SQ_WRITE:  state_d = SQ_IDLE;
         default:   state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= SQ_IDLE;
         cmd_q   <= '0;
      end else begin
         state_q <= state_d;
         if (accept) cmd_q <= cmd;
      end
   end

   always_comb begin
      state  = state_q;
      busy   = (state_q != SQ_IDLE);
      done   = (state_q == SQ_WRITE);
      rd_acc = (state_q == SQ_RD_DST) ? cmd_q.dst : cmd_q.src;
   end

   // R8: done is a single pulse inside the busy window
   a_r8_done_within_busy: assert property (@(posedge clk) disable iff (rst)
      done |-> busy);
   a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   a_r8_accept_starts_busy: assert property (@(posedge clk) disable iff (rst)
      (start && cmd.hit && !busy) |=> busy);
   // R3: a move writes straight after reading its source
   a_r3_move_two_cycles: assert property (@(posedge clk) disable iff (rst)
      (state_q == SQ_RD_SRC && cmd_q.op == XOP_MOVE) |=> done);
   // R6: a merge goes source read, destination read, write
   a_r6_merge_three_cycles: assert property (@(posedge clk) disable iff (rst)
      (state_q == SQ_RD_SRC && cmd_q.op != XOP_MOVE) |=> (busy && !done) ##1 done);

endmodule

// File: rtl/acc_xfer_unit.sv
module acc_xfer_unit
   import acc_xfer_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int OPC_W    = 16,
   parameter bit LOGIC_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [OPC_W-1:0]  opcode,
   input  logic              load_en,
   input  logic [2:0]        load_sel,
   input  logic [DATA_W-1:0] load_data,
   input  logic [2:0]        peek_sel,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic              done,
   output logic              flag_z,
   output logic              flag_n
);

   localparam int NREG  = 7;
   localparam int SEL_W = $clog2(NREG);

   if (DATA_W < 2) begin : g_bad_data
      $error("acc_xfer_unit: DATA_W must be at least 2");
   end

   xfer_cmd_t cmd, cmd_q;
   seq_e      state;
   logic [ACC_SEL_W-1:0] rd_acc;

   logic [SEL_W-1:0]  rf_rd_sel, rf_wr_sel;
   logic              rf_wr_en;
   logic [DATA_W-1:0] rf_wr_data, rf_rd_data;
   logic [DATA_W-1:0] operand_q, result_q, merged;

   acc_xfer_decode #(.OPC_W(OPC_W), .LOGIC_EN(LOGIC_EN)) u_decode (
      .opcode (opcode),
      .cmd    (cmd)
   );

   acc_xfer_seq u_seq (
      .clk    (clk),
      .rst    (rst),
      .start  (start),
      .cmd    (cmd),
      .state  (state),
      .cmd_q  (cmd_q),
      .rd_acc (rd_acc),
      .busy   (busy),
      .done   (done)
   );

   acc_xfer_regfile #(.DATA_W(DATA_W), .NREG(NREG), .SEL_W(SEL_W)) u_rf (
      .clk     (clk),
      .rst     (rst),
      .rd_sel  (rf_rd_sel),
      .rd_data (rf_rd_data),
      .wr_en   (rf_wr_en),
      .wr_sel  (rf_wr_sel),
      .wr_data (rf_wr_data)
   );

   // single read port: sequencer owns it while busy, observation otherwise
   always_comb begin
      rf_rd_sel = busy ? {{(SEL_W-ACC_SEL_W){1'b0}}, rd_acc} : SEL_W'(peek_sel);
      rd_data   = rf_rd_data;
   end

   always_comb begin
      unique case (cmd_q.op)
         XOP_AND: merged = operand_q & rf_rd_data;
         XOP_OR:  merged = operand_q | rf_rd_data;
         XOP_XOR: merged = operand_q ^ rf_rd_data;
         default: merged = operand_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         operand_q <= '0;
         result_q  <= '0;
      end else if (state == SQ_RD_SRC) begin
         operand_q <= rf_rd_data;
         result_q  <= rf_rd_data;
      end else if (state == SQ_RD_DST) begin
         result_q  <= merged;
      end
   end

   always_comb begin
      if (done) begin
         rf_wr_en   = 1'b1;
         rf_wr_sel  = {{(SEL_W-ACC_SEL_W){1'b0}}, cmd_q.dst};
         rf_wr_data = result_q;
      end else begin
         rf_wr_en   = load_en && !busy;
         rf_wr_sel  = SEL_W'(load_sel);
         rf_wr_data = load_data;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         flag_z <= 1'b0;
         flag_n <= 1'b0;
      end else if (done) begin
         flag_z <= (result_q == '0);
         flag_n <= result_q[DATA_W-1];
      end
   end

   // R9: flags follow the value just written
   a_r9_zero_flag: assert property (@(posedge clk) disable iff (rst)
      done |=> (flag_z == ($past(result_q) == '0)));
   a_r9_flags_hold: assert property (@(posedge clk) disable iff (rst)
      !done |=> ($stable(flag_z) && $stable(flag_n)));
   // R10: the load path never reaches the file while a transfer runs
   a_r10_load_blocked: assert property (@(posedge clk) disable iff (rst)
      (busy && !done) |-> !rf_wr_en);
   // R10: transfers only target accumulators
   a_r10_acc_only: assert property (@(posedge clk) disable iff (rst)
      done |-> (rf_wr_sel < SEL_W'(4)));

endmodule

// File: tb/acc_xfer_unit_tb.sv
module acc_xfer_unit_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [15:0] opcode = '0;
   logic        load_en = 1'b0;
   logic [2:0]  load_sel = '0;
   logic [15:0] load_data = '0;
   logic [2:0]  peek_sel = '0;
   logic [15:0] rd_data;
   logic        busy, done, flag_z, flag_n;

   always #5 clk = ~clk;

   acc_xfer_unit u_dut (
      .clk(clk), .rst(rst), .start(start), .opcode(opcode),
      .load_en(load_en), .load_sel(load_sel), .load_data(load_data),
      .peek_sel(peek_sel), .rd_data(rd_data), .busy(busy), .done(done),
      .flag_z(flag_z), .flag_n(flag_n)
   );

   int checks = 0;
   int errors = 0;
   string cur_req = "R11";
   bit armed = 1'b0;
   bit finished = 1'b0;

   // reference model
   logic [15:0] mr [8];
   int          cnt = 0;
   int          mdst = 0;
   logic [15:0] mval = '0;
   logic        mz = 1'b0, mn = 1'b0;

   function automatic bit in_family(input logic [15:0] op);
      return (op[15:12] == 4'h0) && (op[7:6] == 2'b10) && (op[3:0] == 4'hB);
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < 8; i++) mr[i] = '0;
         cnt = 0; mz = 1'b0; mn = 1'b0;
      end else if (cnt > 0) begin
         cnt = cnt - 1;
         if (cnt == 0) begin
            mr[mdst] = mval;
            mz = (mval == 16'h0);
            mn = mval[15];
         end
      end else begin
         if (load_en && load_sel != 3'd7) mr[load_sel] = load_data;
         if (start && in_family(opcode)) begin
            int s, d;
            s = opcode[5:4];
            d = opcode[9:8];
            mdst = d;
            case (opcode[11:10])
               2'b01: mval = mr[s] & mr[d];
               2'b10: mval = mr[s] | mr[d];
               2'b11: mval = mr[s] ^ mr[d];
               default: mval = mr[s];
            endcase
            cnt = (opcode[11:10] == 2'b00) ? 2 : 3;
         end
      end
   end

   task automatic cmp(input string what, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (armed && !finished) begin
         cmp("busy", {15'h0, busy}, {15'h0, cnt > 0});
         cmp("done", {15'h0, done}, {15'h0, cnt == 1});
         cmp("flag_z", {15'h0, flag_z}, {15'h0, mz});
         cmp("flag_n", {15'h0, flag_n}, {15'h0, mn});
         if (cnt == 0) cmp("rd_data", rd_data, mr[peek_sel]);
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
      start = 1'b0;
      load_en = 1'b0;
      peek_sel = peek_sel + 3'd1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic load(input logic [2:0] sel, input logic [15:0] val);
      load_en = 1'b1; load_sel = sel; load_data = val;
      tick();
   endtask

   task automatic issue(input logic [15:0] op);
      start = 1'b1; opcode = op;
      tick();
   endtask

   task automatic seed();
      load(3'd0, 16'h1234);
      load(3'd1, 16'h00F0);
      load(3'd2, 16'h8001);
      load(3'd3, 16'h0F0F);
   endtask

   function automatic logic [15:0] mk(input int op, input int d, input int s);
      return {4'h0, 2'(op), 2'(d), 2'b10, 2'(s), 4'hB};
   endfunction

   initial begin
      #1;
      idle(2);
      rst = 1'b0;
      armed = 1'b1;
      // R11: reset state of file and flags
      cur_req = "R11";
      idle(8);
      // R10: loads into every register, including X, Y, S
      cur_req = "R10";
      seed();
      load(3'd4, 16'h1111); load(3'd5, 16'h2222); load(3'd6, 16'h3333);
      load(3'd7, 16'hDEAD);
      idle(8);
      // R2 R3: every distinct source/destination pair
      cur_req = "R3";
      for (int s = 0; s < 4; s++)
         for (int d = 0; d < 4; d++)
            if (s != d) begin
               seed(); issue(mk(0, d, s)); idle(4);
            end
      cur_req = "R2";
      seed(); issue(16'h018B); idle(3); issue(16'h009B); idle(8);
      // R4: same-register transfers
      cur_req = "R4";
      for (int s = 0; s < 4; s++) begin issue(mk(0, s, s)); idle(3); end
      idle(8);
      // R5 R6: merges over all pairs
      cur_req = "R6";
      for (int op = 1; op < 4; op++)
         for (int s = 0; s < 4; s++)
            for (int d = 0; d < 4; d++) begin
               seed(); issue(mk(op, d, s)); idle(4);
            end
      cur_req = "R5";
      seed(); issue(16'h058B); idle(4); issue(16'h0A9B); idle(4); issue(16'h0FAB); idle(8);
      // R9: zero and negative results
      cur_req = "R9";
      load(3'd0, 16'h00FF); load(3'd1, 16'h00FF);
      issue(16'h0D8B); idle(4);                 // A xor B -> B: zero
      load(3'd2, 16'h8000);
      issue(16'h09AB); idle(4);                 // C or B -> B: negative
      issue(16'h058B); idle(8);                 // A and B -> B: zero again
      // R1: opcodes outside the family
      cur_req = "R1";
      seed();
      issue(16'h108B); idle(2); issue(16'h00CB); idle(2);
      issue(16'h008A); idle(2); issue(16'h004B); idle(2);
      issue(16'h800B); idle(8);
      // R8: start repeated during busy
      cur_req = "R8";
      seed();
      issue(16'h0D8B); start = 1'b1; opcode = 16'h039B; tick();
      start = 1'b1; opcode = 16'h02BB; tick(); idle(8);
      // R10: load during busy is dropped
      cur_req = "R10";
      seed();
      issue(16'h018B); load(3'd1, 16'hBEEF); idle(3);
      issue(16'h0A8B); load(3'd4, 16'hCAFE); load(3'd0, 16'h5555); idle(8);
      // R7: observation sweep of all codes
      cur_req = "R7";
      idle(16);
      // R11: reset in the middle of a merge
      cur_req = "R11";
      seed(); issue(16'h0E8B); tick();
      rst = 1'b1; tick(); rst = 1'b0; idle(10);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1000000;
      if (!finished) begin
         finished = 1'b1;
         errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule